// File: doc/BRIEF.md
# USB IN Endpoint Bank Controller

This block holds the outgoing data of one device-side USB IN endpoint in one or two byte banks. Firmware fills a bank one byte at a time through a data port, then hands the bank to the host side by writing 0 to a release bit. A CPU-clearable ready flag tells firmware that a fresh bank is free. It can be read by polling or routed to an interrupt line through an enable. A write-allowed status bit tells firmware whether the current bank still has room.

On the host side, a simplified token port receives IN tokens. If the bank at the host pointer has not been committed, the block answers NAK. Otherwise it announces a packet with its length and streams the bytes one per cycle. When the host's ACK arrives, the bank is emptied and returned to firmware. Banks are used in strict alternation. With two banks, firmware can fill one bank while the host drains the other. A commit then re-raises the ready flag in the same edge if the other bank is already free.

Top module: `usb_in_bank_ctrl`

## Requirements
- R1: After synchronous reset no bank holds data, and `bank_ready`, `bank_release` and `write_allowed` are 0 while `ep_enable` is 0. `tx_nak`, `tx_start` and `tx_valid` are 0.
- R2: `bank_ready` is set on the edge at which the endpoint is enabled and the current CPU bank is free. `irq` equals `bank_ready` AND `irq_en`.
- R3: A register write of 0 to the ready flag (`cpu_rdy_we`=1, `cpu_rdy_wdata`=0) clears `bank_ready`. A write of 1 leaves it unchanged.
- R4: `write_allowed` is 1 exactly when `bank_release` is 1 and the current bank holds fewer than BANK_BYTES bytes. A data write while it is 0 is ignored: no byte is stored and no count changes.
- R5: `bank_release` is 1 while the endpoint is enabled and the current CPU bank is not committed. Writing 0 to it while it is 1 commits the bank and advances the CPU bank pointer. Writing 1, or writing 0 while it is 0, has no effect.
- R6: With two banks, if the other bank is free when a commit is written, `bank_ready` and `bank_release` are both 1 in the cycle after that write.
- R7: An IN token while the bank at the host pointer is not committed gives a one-cycle `tx_nak` in the next cycle.
- R8: An IN token for a committed bank gives `tx_start` with `tx_len` equal to that bank's byte count in the next cycle. The bytes then follow on `tx_valid`/`tx_data` in consecutive cycles in write order, with `tx_last` on the final byte. A zero-length bank sends no bytes.
- R9: `host_ack` after a packet frees that bank and advances the host pointer. If firmware had no free bank, `bank_ready` is 1 in the cycle after the ACK.
- R10: An IN token while an ACK is awaited re-sends the same bank. `host_ack` at any other time is ignored.
- R11: Banks are used alternately, bank 0 first, so packets reach the host in commit order with their bytes intact.
- R12: While `ep_enable` is 0, `bank_ready`, `bank_release` and `write_allowed` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ep_enable | input | 1 | Endpoint enabled |
| irq_en | input | 1 | Interrupt enable for the ready flag |
| cpu_data_we | input | 1 | Data port write strobe |
| cpu_data | input | 8 | Data byte from firmware |
| cpu_rdy_we | input | 1 | Ready flag register write strobe |
| cpu_rdy_wdata | input | 1 | Value written to the ready flag |
| cpu_rel_we | input | 1 | Release bit register write strobe |
| cpu_rel_wdata | input | 1 | Value written to the release bit |
| bank_ready | output | 1 | Ready flag: a free bank awaits firmware |
| bank_release | output | 1 | Release bit: firmware owns the current bank |
| write_allowed | output | 1 | Current bank has room for a byte |
| irq | output | 1 | Endpoint interrupt |
| in_token | input | 1 | IN token pulse from the host side |
| host_ack | input | 1 | ACK handshake pulse from the host |
| tx_nak | output | 1 | NAK answer pulse |
| tx_start | output | 1 | Packet start pulse, qualifies tx_len |
| tx_len | output | CNT_W | Packet payload length in bytes |
| tx_valid | output | 1 | Payload byte valid |
| tx_data | output | 8 | Payload byte |
| tx_last | output | 1 | Final payload byte |

## Verification
The hardest state to reach is the one where both banks are committed and firmware is blocked. In that state the release bit and write-allowed are 0, and the ready flag must come back on the very edge of the host's ACK. The stimulus reaches it by letting the random loop commit a second bank before draining the first. It clears the ready flag at the start of every fill, so the flag's return after the ACK can be seen in isolation. Full banks of exactly BANK_BYTES bytes, with an extra write that must be dropped, and zero-length banks are drawn deliberately often. Re-sent packets after a repeated token are mixed in.

// File: rtl/usb_in_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the IN endpoint bank controller.
// Assumes: byte-wide data path on both sides.
package usb_in_pkg;
    localparam int DATA_W = 8;

    // Host-side packet sequencing states
    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_SEND = 2'd1,
        HS_WAIT = 2'd2
    } host_state_e;
endpackage

// File: rtl/usb_in_bank_mem.sv
`timescale 1ns/1ps
// Bank storage: NUM_BANKS arrays of BANK_BYTES bytes.
// One synchronous write port and one combinational read port.
// Assumes: indices are kept in range by the callers; contents are not reset.
module usb_in_bank_mem #(
    parameter int NUM_BANKS  = 2,
    parameter int BANK_BYTES = 64,
    parameter int IDX_W      = 6,
    parameter int DATA_W     = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic              wbank,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rbank,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] store [NUM_BANKS][BANK_BYTES];

    // Store one byte from the firmware side
    always_ff @(posedge clk) begin
        if (we) begin
            store[wbank][widx] <= wdata;
        end
    end

    // Present the byte the host side points at
    assign rdata = store[rbank][ridx];
endmodule

// File: rtl/usb_in_cpu_ctrl.sv
`timescale 1ns/1ps
// Firmware-side control: owns the CPU bank pointer, per-bank byte counts,
// per-bank commit flags, the ready flag and the release / write-allowed bits.
// Assumes: free_vld only names a committed bank, which is never the bank
// being written, so count updates never collide.
module usb_in_cpu_ctrl #(
    parameter int NUM_BANKS  = 2,
    parameter int BANK_BYTES = 64,
    parameter int CNT_W      = 7,
    parameter int IDX_W      = 6
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            ep_enable,
    input  logic                            cpu_data_we,
    input  logic                            cpu_rdy_we,
    input  logic                            cpu_rdy_wdata,
    input  logic                            cpu_rel_we,
    input  logic                            cpu_rel_wdata,
    input  logic                            free_vld,
    input  logic                            free_bank,
    output logic                            rdy_flag,
    output logic                            rel_bit,
    output logic                            wr_allow,
    output logic                            mem_we,
    output logic                            mem_bank,
    output logic [IDX_W-1:0]                mem_idx,
    output logic [NUM_BANKS-1:0]            committed,
    output logic [NUM_BANKS-1:0][CNT_W-1:0] bank_cnt
);
    logic                 cpu_ptr, cpu_ptr_n, ptr_step;
    logic                 announced, announced_n, base_ann;
    logic                 commit, avail_n, set_ev, rdy_n;
    logic [NUM_BANKS-1:0] cmt_n;

    // Pointer advance: toggles with two banks, stays on bank 0 with one
    generate
        if (NUM_BANKS == 2) begin : g_two_banks
            assign ptr_step = ~cpu_ptr;
        end else begin : g_one_bank
            assign ptr_step = 1'b0;
        end
    endgenerate

    // Status bits and accepted firmware actions for this cycle
    always_comb begin
        rel_bit  = ep_enable && !committed[cpu_ptr];
        wr_allow = rel_bit && (bank_cnt[cpu_ptr] < CNT_W'(BANK_BYTES));
        mem_we   = cpu_data_we && wr_allow;
        mem_bank = cpu_ptr;
        mem_idx  = bank_cnt[cpu_ptr][IDX_W-1:0];
        commit   = cpu_rel_we && !cpu_rel_wdata && rel_bit;
    end

    // Next ownership and ready flag, looking ahead so a commit onto a free
    // bank, or a host release onto a blocked CPU, raises the flag at once
    always_comb begin
        cmt_n = committed;
        if (commit)   cmt_n[cpu_ptr]   = 1'b1;
        if (free_vld) cmt_n[free_bank] = 1'b0;
        cpu_ptr_n   = commit ? ptr_step : cpu_ptr;
        base_ann    = announced && !commit;
        avail_n     = ep_enable && !cmt_n[cpu_ptr_n];
        set_ev      = avail_n && !base_ann;
        rdy_n       = ep_enable && (set_ev || (rdy_flag && !(cpu_rdy_we && !cpu_rdy_wdata)));
        announced_n = ep_enable && (base_ann || set_ev);
    end

    // Register ownership, pointer, flags and byte counts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            committed <= '0;
            cpu_ptr   <= 1'b0;
            announced <= 1'b0;
            rdy_flag  <= 1'b0;
            bank_cnt  <= '0;
        end else begin
            committed <= cmt_n;
            cpu_ptr   <= cpu_ptr_n;
            announced <= announced_n;
            rdy_flag  <= rdy_n;
            if (mem_we)   bank_cnt[cpu_ptr]   <= bank_cnt[cpu_ptr] + CNT_W'(1);
            if (free_vld) bank_cnt[free_bank] <= '0;
        end
    end
endmodule

// File: rtl/usb_in_host_tx.sv
`timescale 1ns/1ps
// Host-side sequencer: answers IN tokens with NAK or with a packet read
// from the bank at the host pointer, then frees that bank on ACK.
// Assumes: tokens arriving while a packet streams out are dropped.
module usb_in_host_tx
    import usb_in_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int CNT_W     = 7,
    parameter int IDX_W     = 6
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            in_token,
    input  logic                            host_ack,
    input  logic [NUM_BANKS-1:0]            committed,
    input  logic [NUM_BANKS-1:0][CNT_W-1:0] bank_cnt,
    input  logic [DATA_W-1:0]               rd_data,
    output logic                            rd_bank,
    output logic [IDX_W-1:0]                rd_idx,
    output logic                            free_vld,
    output logic                            free_bank,
    output logic                            tx_nak,
    output logic                            tx_start,
    output logic [CNT_W-1:0]                tx_len,
    output logic                            tx_valid,
    output logic [DATA_W-1:0]               tx_data,
    output logic                            tx_last
);
    host_state_e      state;
    logic             host_ptr, ptr_step, cur_cmt, last_byte;
    logic [CNT_W-1:0] idx, cur_len;

    // Pointer advance variant picked by the bank count
    generate
        if (NUM_BANKS == 2) begin : g_two_banks
            assign ptr_step = ~host_ptr;
        end else begin : g_one_bank
            assign ptr_step = 1'b0;
        end
    endgenerate

    // Current bank view, read address and release request
    always_comb begin
        cur_len   = bank_cnt[host_ptr];
        cur_cmt   = committed[host_ptr];
        rd_bank   = host_ptr;
        rd_idx    = idx[IDX_W-1:0];
        last_byte = (idx + CNT_W'(1)) == cur_len;
        free_vld  = (state == HS_WAIT) && host_ack && !in_token;
        free_bank = host_ptr;
    end

    // Token handling, byte streaming and ACK bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= HS_IDLE;
            host_ptr <= 1'b0;
            idx      <= '0;
            tx_nak   <= 1'b0;
            tx_start <= 1'b0;
            tx_len   <= '0;
            tx_valid <= 1'b0;
            tx_data  <= '0;
            tx_last  <= 1'b0;
        end else begin
            tx_nak   <= 1'b0;
            tx_start <= 1'b0;
            tx_valid <= 1'b0;
            tx_last  <= 1'b0;
            case (state)
                HS_SEND: begin
                    tx_valid <= 1'b1;
                    tx_data  <= rd_data;
                    tx_last  <= last_byte;
                    idx      <= idx + CNT_W'(1);
                    if (last_byte) state <= HS_WAIT;
                end
                default: begin
                    if (in_token) begin
                        if (cur_cmt) begin
                            tx_start <= 1'b1;
                            tx_len   <= cur_len;
                            idx      <= '0;
                            state    <= (cur_len == '0) ? HS_WAIT : HS_SEND;
                        end else begin
                            tx_nak <= 1'b1;
                        end
                    end else if (free_vld) begin
                        state    <= HS_IDLE;
                        host_ptr <= ptr_step;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/usb_in_bank_ctrl.sv
`timescale 1ns/1ps
// USB IN endpoint bank controller, top level.
// Ties the firmware-side control, the bank storage and the host-side
// sequencer together. Assumes NUM_BANKS is 1 or 2 and that the host side
// issues one-cycle token and ACK pulses.
module usb_in_bank_ctrl
    import usb_in_pkg::*;
#(
    parameter int  NUM_BANKS  = 2,
    parameter int  BANK_BYTES = 64,
    localparam int CNT_W      = $clog2(BANK_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ep_enable,
    input  logic              irq_en,
    input  logic              cpu_data_we,
    input  logic [DATA_W-1:0] cpu_data,
    input  logic              cpu_rdy_we,
    input  logic              cpu_rdy_wdata,
    input  logic              cpu_rel_we,
    input  logic              cpu_rel_wdata,
    output logic              bank_ready,
    output logic              bank_release,
    output logic              write_allowed,
    output logic              irq,
    input  logic              in_token,
    input  logic              host_ack,
    output logic              tx_nak,
    output logic              tx_start,
    output logic [CNT_W-1:0]  tx_len,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_last
);
    localparam int IDX_W = (BANK_BYTES > 1) ? $clog2(BANK_BYTES) : 1;

    logic                            mem_we, mem_bank, rd_bank;
    logic [IDX_W-1:0]                mem_idx, rd_idx;
    logic [DATA_W-1:0]               rd_data;
    logic                            free_vld, free_bank;
    logic [NUM_BANKS-1:0]            committed;
    logic [NUM_BANKS-1:0][CNT_W-1:0] bank_cnt;

    usb_in_cpu_ctrl #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_BYTES(BANK_BYTES),
        .CNT_W     (CNT_W),
        .IDX_W     (IDX_W)
    ) i_cpu_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .ep_enable    (ep_enable),
        .cpu_data_we  (cpu_data_we),
        .cpu_rdy_we   (cpu_rdy_we),
        .cpu_rdy_wdata(cpu_rdy_wdata),
        .cpu_rel_we   (cpu_rel_we),
        .cpu_rel_wdata(cpu_rel_wdata),
        .free_vld     (free_vld),
        .free_bank    (free_bank),
        .rdy_flag     (bank_ready),
        .rel_bit      (bank_release),
        .wr_allow     (write_allowed),
        .mem_we       (mem_we),
        .mem_bank     (mem_bank),
        .mem_idx      (mem_idx),
        .committed    (committed),
        .bank_cnt     (bank_cnt)
    );

    usb_in_bank_mem #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_BYTES(BANK_BYTES),
        .IDX_W     (IDX_W),
        .DATA_W    (DATA_W)
    ) i_bank_mem (
        .clk  (clk),
        .we   (mem_we),
        .wbank(mem_bank),
        .widx (mem_idx),
        .wdata(cpu_data),
        .rbank(rd_bank),
        .ridx (rd_idx),
        .rdata(rd_data)
    );

    usb_in_host_tx #(
        .NUM_BANKS(NUM_BANKS),
        .CNT_W    (CNT_W),
        .IDX_W    (IDX_W)
    ) i_host_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_token (in_token),
        .host_ack (host_ack),
        .committed(committed),
        .bank_cnt (bank_cnt),
        .rd_data  (rd_data),
        .rd_bank  (rd_bank),
        .rd_idx   (rd_idx),
        .free_vld (free_vld),
        .free_bank(free_bank),
        .tx_nak   (tx_nak),
        .tx_start (tx_start),
        .tx_len   (tx_len),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_last  (tx_last)
    );

    // Interrupt: ready flag gated by its enable
    assign irq = bank_ready && irq_en;
endmodule

// File: rtl/usb_in_bank_ctrl_chk.sv
`timescale 1ns/1ps
// Property checker for the IN endpoint bank controller, bound to the top.
// Assumes: observes ports only; reset is synchronous and active low.
module usb_in_bank_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic ep_enable,
    input logic cpu_rdy_we,
    input logic cpu_rdy_wdata,
    input logic bank_ready,
    input logic bank_release,
    input logic in_token,
    input logic host_ack,
    input logic tx_nak,
    input logic tx_start,
    input logic tx_valid,
    input logic tx_last
);
    // R2: the ready flag only rises when a bank is handed to firmware
    a_r2_ready_rise_with_bank: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bank_ready) |-> (bank_release || !ep_enable));

    // R3: the ready flag only falls after a clear write or a disable
    a_r3_ready_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bank_ready) |-> ($past(cpu_rdy_we && !cpu_rdy_wdata) || $past(!ep_enable)));

    // R7: a NAK answers a token seen one cycle earlier
    a_r7_nak_after_token: assert property (@(posedge clk) disable iff (!rst_n)
        tx_nak |-> $past(in_token));

    // R8: a packet start answers a token seen one cycle earlier
    a_r8_start_after_token: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> $past(in_token));

    // R8: answer kinds never overlap
    a_r8_answers_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_nak, tx_start, tx_valid}));

    // R8: the final byte is followed by a gap in the stream
    a_r8_last_then_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_last) |=> !tx_valid);

    // R10: an ACK never produces an answer on the host side
    a_r10_ack_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ack && !in_token) |=> (!tx_nak && !tx_start));

    // R12: with the endpoint disabled, firmware owns no bank
    a_r12_disabled_no_bank: assert property (@(posedge clk) disable iff (!rst_n)
        !ep_enable |-> !bank_release);
endmodule

bind usb_in_bank_ctrl usb_in_bank_ctrl_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ep_enable    (ep_enable),
    .cpu_rdy_we   (cpu_rdy_we),
    .cpu_rdy_wdata(cpu_rdy_wdata),
    .bank_ready   (bank_ready),
    .bank_release (bank_release),
    .in_token     (in_token),
    .host_ack     (host_ack),
    .tx_nak       (tx_nak),
    .tx_start     (tx_start),
    .tx_valid     (tx_valid),
    .tx_last      (tx_last)
);

// File: tb/test_usb_in_bank_ctrl.sv
`timescale 1ns/1ps
// Bench: directed corner cases followed by seeded random fill/drain traffic,
// compared against a packet queue model kept in the bench.
module test_usb_in_bank_ctrl;
    localparam int NB = 2;
    localparam int BB = 64;
    localparam int CW = $clog2(BB + 1);

    logic          clk = 1'b0;
    logic          rst_n, ep_enable, irq_en;
    logic          cpu_data_we, cpu_rdy_we, cpu_rdy_wdata, cpu_rel_we, cpu_rel_wdata;
    logic [7:0]    cpu_data;
    logic          bank_ready, bank_release, write_allowed, irq;
    logic          in_token, host_ack;
    logic          tx_nak, tx_start, tx_valid, tx_last;
    logic [CW-1:0] tx_len;
    logic [7:0]    tx_data;

    int   n_checks = 0;
    int   n_errors = 0;
    bit   finished = 1'b0;
    logic [7:0] q_data [2][BB];
    int   q_len [2];
    int   q_wr = 0;
    int   q_rd = 0;
    int   q_n  = 0;

    always #2.5 clk = ~clk;

    usb_in_bank_ctrl #(.NUM_BANKS(NB), .BANK_BYTES(BB)) i_usb_in_bank_ctrl (
        .clk(clk), .rst_n(rst_n), .ep_enable(ep_enable), .irq_en(irq_en),
        .cpu_data_we(cpu_data_we), .cpu_data(cpu_data),
        .cpu_rdy_we(cpu_rdy_we), .cpu_rdy_wdata(cpu_rdy_wdata),
        .cpu_rel_we(cpu_rel_we), .cpu_rel_wdata(cpu_rel_wdata),
        .bank_ready(bank_ready), .bank_release(bank_release),
        .write_allowed(write_allowed), .irq(irq),
        .in_token(in_token), .host_ack(host_ack),
        .tx_nak(tx_nak), .tx_start(tx_start), .tx_len(tx_len),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    task automatic cpu_write(input logic [7:0] b);
        cpu_data = b; cpu_data_we = 1'b1;
        step();
        cpu_data_we = 1'b0;
    endtask

    task automatic write_rdy(input logic v);
        cpu_rdy_we = 1'b1; cpu_rdy_wdata = v;
        step();
        cpu_rdy_we = 1'b0;
    endtask

    task automatic write_rel(input logic v);
        cpu_rel_we = 1'b1; cpu_rel_wdata = v;
        step();
        cpu_rel_we = 1'b0;
    endtask

    task automatic token();
        in_token = 1'b1;
        step();
        in_token = 1'b0;
    endtask

    // Fill the current CPU bank with len random bytes and commit it
    task automatic fill(input int len);
        write_rdy(1'b0);
        chk("R3 clear ready", bank_ready, 0);
        chk("R4 room at start", write_allowed, 1);
        for (int i = 0; i < len; i++) begin
            logic [7:0] b;
            b = 8'($urandom);
            q_data[q_wr][i] = b;
            cpu_write(b);
        end
        if (len == BB) begin
            chk("R4 full bank", write_allowed, 0);
            chk("R5 release held when full", bank_release, 1);
            cpu_write(8'h5A);
        end
        write_rel(1'b0);
        q_len[q_wr] = len;
        q_wr ^= 1;
        q_n++;
        if (q_n < 2) begin
            chk("R6 ready at commit", bank_ready, 1);
            chk("R6 release at commit", bank_release, 1);
        end else begin
            chk("R5 no bank left", bank_release, 0);
            chk("R4 no room left", write_allowed, 0);
            chk("R5 no ready", bank_ready, 0);
        end
    endtask

    // Follow one announced packet and compare it with the model
    task automatic stream();
        chk("R8 start", tx_start, 1);
        chk("R8 length", int'(tx_len), q_len[q_rd]);
        for (int k = 0; k < q_len[q_rd]; k++) begin
            step();
            chk("R8 valid", tx_valid, 1);
            chk("R11 byte", tx_data, q_data[q_rd][k]);
            chk("R8 last", tx_last, (k == q_len[q_rd] - 1) ? 1 : 0);
        end
    endtask

    task automatic drain(input bit retry);
        bit blocked;
        blocked = (q_n == 2);
        token();
        stream();
        if (retry) begin
            token();
            stream();
        end
        host_ack = 1'b1;
        step();
        host_ack = 1'b0;
        chk("R8 no byte after packet", tx_valid, 0);
        q_rd ^= 1;
        q_n--;
        if (blocked) chk("R9 ready after ack", bank_ready, 1);
    endtask

    task automatic nak_probe();
        token();
        chk("R7 nak", tx_nak, 1);
        chk("R7 no start", tx_start, 0);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; ep_enable = 1'b0; irq_en = 1'b0;
        cpu_data_we = 1'b0; cpu_data = '0; cpu_rdy_we = 1'b0; cpu_rdy_wdata = 1'b0;
        cpu_rel_we = 1'b0; cpu_rel_wdata = 1'b0; in_token = 1'b0; host_ack = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R1 ready", bank_ready, 0);
        chk("R1 release", bank_release, 0);
        chk("R1 room", write_allowed, 0);
        chk("R1 tx idle", tx_valid | tx_start | tx_nak, 0);

        nak_probe();

        ep_enable = 1'b1;
        step();
        chk("R2 ready on enable", bank_ready, 1);
        chk("R2 irq masked", irq, 0);
        irq_en = 1'b1;
        step();
        chk("R2 irq", irq, 1);

        write_rdy(1'b1);
        chk("R3 write one ignored", bank_ready, 1);
        write_rdy(1'b0);
        chk("R3 cleared", bank_ready, 0);
        chk("R2 irq follows", irq, 0);

        write_rel(1'b1);
        chk("R5 write one ignored", bank_release, 1);
        nak_probe();

        // Two banks committed: bank 0 short, bank 1 full
        fill(3);
        fill(BB);
        cpu_write(8'hEE);
        write_rel(1'b0);
        write_rel(1'b1);
        chk("R5 stays blocked", bank_release, 0);
        host_ack = 1'b1;
        step();
        host_ack = 1'b0;
        chk("R10 ack ignored", bank_ready, 0);
        drain(1'b1);
        drain(1'b0);
        fill(0);
        drain(1'b1);

        // Random traffic against the queue model
        for (int it = 0; it < 60; it++) begin
            int r;
            r = int'($urandom % 4);
            if (q_n < 2 && (r != 0 || q_n == 0)) begin
                int sel, len;
                sel = int'($urandom % 8);
                len = (sel == 0) ? 0 : (sel == 1) ? BB : int'($urandom % (BB - 1)) + 1;
                if (q_n == 0 && r == 3) nak_probe();
                fill(len);
            end else begin
                drain(($urandom % 4) == 0);
            end
        end
        while (q_n > 0) drain(1'b0);
        nak_probe();

        ep_enable = 1'b0;
        step();
        chk("R12 ready off", bank_ready, 0);
        chk("R12 release off", bank_release, 0);
        chk("R12 room off", write_allowed, 0);
        summary();
    end
endmodule